// File: doc/BRIEF.md
# Retry-Driven Legacy Decode Arbiter

This block sits between a primary bus target and a bridge to a slower legacy bus. It governs cycles that land in an address window flagged for routing to that legacy side. The initiator of such a cycle is always told to retry on its first attempt. This gives a downstream agent time to find out whether any legacy target will accept the address.

Once the downstream agent has claimed the cycle, it reports one of two results: a positive decode, which ends the cycle with a normal-completion pulse, or a target abort. After a target abort, the block lets the next retry of the initiator through without a retry. That attempt can then fall back to the host's own local bus.

A 3-bit configuration value caps how many further retries the initiator may make. The attempt that would go past the cap raises a one-cycle system-error pulse instead. Only one routed cycle is tracked at a time. Every response is a registered pulse that appears one clock after the input that caused it.

Top module: `legacy_route_arbiter`

## Requirements
- R1: While `rst_n` is low at a clock edge, all four response outputs are 0 and the block returns to idle, so a downstream completion arriving right after reset produces no response.
- R2: In idle, `cyc_hit` produces `retry_o`=1 one cycle later, starts a new sequence and clears the retry count to zero.
- R3: While a sequence waits for a downstream result, each `retry_att` whose count is below the limit produces `retry_o`=1 one cycle later and adds one to the count.
- R4: After `ds_claim`, `ds_done` produces `done_o`=1 one cycle later and the block returns to idle.
- R5: After `ds_claim`, `ds_abort` arms a fall-back. The next `retry_att` then produces `pass_o`=1 (and no `retry_o`) one cycle later, and the block returns to idle.
- R6: A `retry_att` arriving while the count already equals `cfg_retry_lim` (0 to 7) produces `serr_o`=1 for exactly one cycle and no `retry_o`. The block is idle again in the cycle after the pulse.
- R7: `cyc_hit` while a sequence is outstanding produces `retry_o`=1 but neither restarts nor alters that sequence.
- R8: `ds_done` and `ds_abort` are ignored until the cycle has been claimed with `ds_claim`.
- R9: `retry_att` in idle produces no output.
- R10: At most one of `pass_o`, `done_o` and `serr_o` is 1 in any cycle.
- R11: When `ds_done` or `ds_abort` coincides with `retry_att` in the waiting state, the downstream event is acted on and that attempt gets neither a retry nor a count increment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_retry_lim | input | 3 | Number of retried attempts allowed before the system error |
| cyc_hit | input | 1 | New primary cycle hit a legacy-routed window |
| retry_att | input | 1 | Initiator retry attempt of the outstanding cycle |
| ds_claim | input | 1 | Downstream agent has claimed the cycle |
| ds_abort | input | 1 | Downstream agent ended with target abort |
| ds_done | input | 1 | Downstream agent found a positive decode |
| retry_o | output | 1 | Retry response pulse |
| pass_o | output | 1 | Pass-through to local bus pulse |
| done_o | output | 1 | Normal completion pulse |
| serr_o | output | 1 | System error pulse |

## Verification
A sequencer stuck in the wrong state shows up at the very next attempt or downstream event. A stray claim state would make a premature `ds_done` raise `done_o`. A lost fall-back arm would answer the post-abort attempt with `retry_o` instead of `pass_o`. A sequence restarted by a busy hit would ignore a later completion. A wrong retry count only shows when the limit is reached: `serr_o` then comes one attempt early or late. The limit is therefore exercised at 0, 2 and 7, so that every count value is reached.

// File: rtl/lra_pkg.sv
// Shared types for the legacy route arbiter.
// Assumes: a single outstanding routed cycle; all responses registered.
package lra_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RETRY_PEND,
        ST_DS_WAIT,
        ST_PASS_ARMED,
        ST_ERROR
    } seq_state_t;

    typedef struct packed {
        logic retry;
        logic pass;
        logic done;
        logic serr;
    } resp_t;

endpackage

// File: rtl/lra_retry_ctr.sv
// Retry counter: counts retried attempts of the outstanding cycle and flags
// when the programmed limit has been reached.
// Assumes: clear wins over increment; the increment is never requested at the limit.
module lra_retry_ctr #(
    parameter int LIM_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_clr,
    input  logic             cnt_inc,
    input  logic [LIM_W-1:0] lim,
    output logic             at_limit
);

    logic [LIM_W-1:0] cnt;

    // Hold the number of retries granted to the current sequence.
    always_ff @(posedge clk) begin
        if (!rst_n)       cnt <= '0;
        else if (cnt_clr) cnt <= '0;
        else if (cnt_inc) cnt <= cnt + 1'b1;
    end

    // Limit reached: the next attempt must not be retried.
    always_comb at_limit = (cnt >= lim);

    // R6
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_inc && !cnt_clr) |-> (cnt < lim));

endmodule

// File: rtl/lra_seq_fsm.sv
// Sequencer for one routed cycle: first retry, downstream wait, fall-back
// arming, error exit. Produces the next-cycle response and counter controls.
// Assumes: downstream results only count after a claim; downstream events
// take precedence over an attempt in the same cycle.
module lra_seq_fsm
    import lra_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  cyc_hit,
    input  logic  retry_att,
    input  logic  ds_claim,
    input  logic  ds_abort,
    input  logic  ds_done,
    input  logic  at_limit,
    output logic  cnt_clr,
    output logic  cnt_inc,
    output resp_t rsp_nxt,
    output logic  is_idle
);

    seq_state_t st, st_nxt, st_base;
    resp_t      rsp_base;
    logic       own_att;

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nxt;
    end

    // Per-state transitions driven by new hits and downstream results.
    always_comb begin
        st_base  = st;
        rsp_base = '0;
        cnt_clr  = 1'b0;
        own_att  = 1'b0;
        case (st)
            ST_IDLE: begin
                if (cyc_hit) begin
                    st_base        = ST_RETRY_PEND;
                    cnt_clr        = 1'b1;
                    rsp_base.retry = 1'b1;
                end
            end
            ST_RETRY_PEND: begin
                if (ds_claim) st_base = ST_DS_WAIT;
                own_att = retry_att;
            end
            ST_DS_WAIT: begin
                if (ds_done) begin
                    rsp_base.done = 1'b1;
                    st_base       = ST_IDLE;
                end else if (ds_abort) begin
                    st_base = ST_PASS_ARMED;
                end else begin
                    own_att = retry_att;
                end
            end
            ST_PASS_ARMED: begin
                if (retry_att) begin
                    rsp_base.pass = 1'b1;
                    st_base       = ST_IDLE;
                end
            end
            ST_ERROR: st_base = ST_IDLE;
            default:  st_base = ST_IDLE;
        endcase
    end

    // Resolve the initiator's attempt against the limit and add busy-hit retries.
    always_comb begin
        st_nxt  = st_base;
        rsp_nxt = rsp_base;
        cnt_inc = 1'b0;
        if (own_att) begin
            if (at_limit) begin
                rsp_nxt.serr = 1'b1;
                st_nxt       = ST_ERROR;
            end else begin
                rsp_nxt.retry = 1'b1;
                cnt_inc       = 1'b1;
            end
        end
        if (cyc_hit && (st != ST_IDLE)) rsp_nxt.retry = 1'b1;
    end

    // Idle flag for neighbours.
    always_comb is_idle = (st == ST_IDLE);

    // R4
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_DS_WAIT && ds_done) |=> (st == ST_IDLE));

    // R5
    pass_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_PASS_ARMED && retry_att) |=> (st == ST_IDLE));

    // R8
    early_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RETRY_PEND && !ds_claim && !retry_att) |=> (st == ST_RETRY_PEND));

    // R6
    err_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_ERROR) |=> (st == ST_IDLE));

endmodule

// File: rtl/lra_resp_reg.sv
// Response stage: registers the sequencer's decision into output pulses.
// Assumes: the sequencer never requests two terminal responses at once.
module lra_resp_reg
    import lra_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  resp_t rsp_d,
    output logic  retry_o,
    output logic  pass_o,
    output logic  done_o,
    output logic  serr_o
);

    resp_t rsp_q;

    // Capture the response for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) rsp_q <= '0;
        else        rsp_q <= rsp_d;
    end

    // Drive the output pins.
    always_comb begin
        retry_o = rsp_q.retry;
        pass_o  = rsp_q.pass;
        done_o  = rsp_q.done;
        serr_o  = rsp_q.serr;
    end

    // R10
    term_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({pass_o, done_o, serr_o}));

    // R6
    serr_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        serr_o |=> !serr_o);

endmodule

// File: rtl/legacy_route_arbiter.sv
// Top of the legacy route arbiter: retries routed primary cycles until a
// downstream decode result arrives, falls back once after an abort, and
// raises a system error when the retry limit is passed.
// Assumes: cycle-hit and retry-attempt come from the primary target decoder.
module legacy_route_arbiter
    import lra_pkg::*;
#(
    parameter int LIM_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LIM_W-1:0] cfg_retry_lim,
    input  logic             cyc_hit,
    input  logic             retry_att,
    input  logic             ds_claim,
    input  logic             ds_abort,
    input  logic             ds_done,
    output logic             retry_o,
    output logic             pass_o,
    output logic             done_o,
    output logic             serr_o
);

    logic  cnt_clr, cnt_inc, at_limit, fsm_idle;
    resp_t rsp_nxt;

    lra_retry_ctr #(.LIM_W(LIM_W)) u_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .cnt_clr  (cnt_clr),
        .cnt_inc  (cnt_inc),
        .lim      (cfg_retry_lim),
        .at_limit (at_limit)
    );

    lra_seq_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cyc_hit   (cyc_hit),
        .retry_att (retry_att),
        .ds_claim  (ds_claim),
        .ds_abort  (ds_abort),
        .ds_done   (ds_done),
        .at_limit  (at_limit),
        .cnt_clr   (cnt_clr),
        .cnt_inc   (cnt_inc),
        .rsp_nxt   (rsp_nxt),
        .is_idle   (fsm_idle)
    );

    lra_resp_reg u_rsp (
        .clk     (clk),
        .rst_n   (rst_n),
        .rsp_d   (rsp_nxt),
        .retry_o (retry_o),
        .pass_o  (pass_o),
        .done_o  (done_o),
        .serr_o  (serr_o)
    );

    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_idle && !cyc_hit) |=> (!retry_o && !pass_o && !done_o && !serr_o));

endmodule

// File: tb/sim_legacy_route_arbiter.sv
`timescale 1ns/1ps
// Bench for the legacy route arbiter: a vector table walk, then directed cases.
module sim_legacy_route_arbiter;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] lim = 3'd2;
    logic       hit = 1'b0, att = 1'b0, claim = 1'b0, abrt = 1'b0, dn = 1'b0;
    logic       retry_o, pass_o, done_o, serr_o;

    int checks = 0;
    int fails  = 0;
    bit ended  = 1'b0;

    always #2.5 clk = ~clk;

    legacy_route_arbiter u0 (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_retry_lim (lim),
        .cyc_hit       (hit),
        .retry_att     (att),
        .ds_claim      (claim),
        .ds_abort      (abrt),
        .ds_done       (dn),
        .retry_o       (retry_o),
        .pass_o        (pass_o),
        .done_o        (done_o),
        .serr_o        (serr_o)
    );

    // Vector: {req, hit att claim abort done, limit, expect retry pass done serr}
    localparam int NV = 22;
    localparam logic [15:0] VEC [NV] = '{
        {4'd1, 5'b00000, 3'd2, 4'b0000}, // R1 quiet after reset
        {4'd2, 5'b10000, 3'd2, 4'b1000}, // R2 first hit retried
        {4'd3, 5'b01000, 3'd2, 4'b1000}, // R3 count 1
        {4'd4, 5'b00100, 3'd2, 4'b0000}, // R4 claim
        {4'd3, 5'b01000, 3'd2, 4'b1000}, // R3 count 2
        {4'd4, 5'b00001, 3'd2, 4'b0010}, // R4 normal completion
        {4'd2, 5'b10000, 3'd2, 4'b1000}, // R2 new sequence
        {4'd5, 5'b00100, 3'd2, 4'b0000}, // R5 claim
        {4'd5, 5'b00010, 3'd2, 4'b0000}, // R5 abort arms fall-back
        {4'd5, 5'b01000, 3'd2, 4'b0100}, // R5 pass-through
        {4'd9, 5'b01000, 3'd2, 4'b0000}, // R9 attempt in idle ignored
        {4'd2, 5'b10000, 3'd2, 4'b1000}, // R2 new sequence, count cleared
        {4'd3, 5'b01000, 3'd2, 4'b1000}, // R3 count 1
        {4'd3, 5'b01000, 3'd2, 4'b1000}, // R3 count 2
        {4'd6, 5'b01000, 3'd2, 4'b0001}, // R6 limit passed
        {4'd6, 5'b00000, 3'd2, 4'b0000}, // R6 pulse is one cycle
        {4'd2, 5'b10000, 3'd2, 4'b1000}, // R2 new sequence
        {4'd8, 5'b00001, 3'd2, 4'b0000}, // R8 done before claim ignored
        {4'd8, 5'b00010, 3'd2, 4'b0000}, // R8 abort before claim ignored
        {4'd4, 5'b00100, 3'd2, 4'b0000}, // R4 claim
        {4'd7, 5'b10000, 3'd2, 4'b1000}, // R7 busy hit retried
        {4'd7, 5'b00001, 3'd2, 4'b0010}  // R7 sequence kept: completion still seen
    };

    task automatic drive(input logic [4:0] v);
        {hit, att, claim, abrt, dn} = v;
    endtask

    // Compare outputs against the expectation; checks in one place.
    task automatic check(input string tag, input logic [3:0] exp);
        logic [3:0] act;
        act = {retry_o, pass_o, done_o, serr_o};
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got retry/pass/done/serr=%b expected %b", tag, act, exp);
        end
    endtask

    // Apply inputs for one cycle, then sample at the following falling edge.
    task automatic step(input logic [4:0] v, input string tag, input logic [3:0] exp);
        drive(v);
        @(negedge clk);
        check(tag, exp);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset", 4'b0000);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            lim = VEC[i][6:4];
            step(VEC[i][11:7], $sformatf("R%0d vec%0d", VEC[i][15:12], i), VEC[i][3:0]);
        end

        // R6 limit of zero: first attempt raises the error
        lim = 3'd0;
        step(5'b10000, "R6 lim0 hit", 4'b1000);
        step(5'b01000, "R6 lim0 first attempt", 4'b0001);
        step(5'b01000, "R6 lim0 back to idle", 4'b0000);

        // R6 limit of seven: seven retries, eighth attempt errors
        lim = 3'd7;
        step(5'b10000, "R6 lim7 hit", 4'b1000);
        for (int k = 0; k < 7; k++) step(5'b01000, "R6 lim7 retry", 4'b1000);
        step(5'b01000, "R6 lim7 eighth attempt", 4'b0001);
        step(5'b00000, "R6 lim7 quiet", 4'b0000);

        // R7 busy hit coinciding with the fall-back attempt
        lim = 3'd2;
        step(5'b10000, "R7 hit", 4'b1000);
        step(5'b00100, "R7 claim", 4'b0000);
        step(5'b00010, "R5 abort", 4'b0000);
        step(5'b11000, "R7 busy hit plus pass", 4'b1100);
        step(5'b00001, "R9 done in idle ignored", 4'b0000);

        // R11 completion wins over a coinciding attempt
        step(5'b10000, "R11 hit", 4'b1000);
        step(5'b00100, "R11 claim", 4'b0000);
        step(5'b01001, "R11 done with attempt", 4'b0010);
        step(5'b01000, "R11 idle after", 4'b0000);

        // R11 abort wins over a coinciding attempt, fall-back stays armed
        step(5'b10000, "R11 hit b", 4'b1000);
        step(5'b00100, "R11 claim b", 4'b0000);
        step(5'b01010, "R11 abort with attempt", 4'b0000);
        step(5'b01000, "R11 pass after abort", 4'b0100);

        // R1 reset in the middle of a claimed sequence
        step(5'b10000, "R1 hit", 4'b1000);
        step(5'b00100, "R1 claim", 4'b0000);
        rst_n = 1'b0;
        step(5'b00000, "R1 mid reset", 4'b0000);
        rst_n = 1'b1;
        step(5'b00001, "R1 done after reset ignored", 4'b0000);
        step(5'b01000, "R1 attempt after reset ignored", 4'b0000);

        ended = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        if (!ended) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule